// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable total ratio. It uses a prescaler that can divide by P or P+1, a swallow counter and a main counter. The prescaler is modelled as a synchronous counter. In each output period, the swallow counter holds the prescaler at P+1 for its first A prescaler cycles. For the rest of the period the prescaler runs at P. The main counter closes the period after N prescaler cycles, so the feedback output `fp` pulses once every N·P + A input cycles.

A separate reference divider runs on the oscillator clock and pulses `fr` once every R oscillator cycles. The two outputs are the inputs of a phase comparator. The block is used to step a synthesizer from channel to channel. New settings are sampled only when a period closes, so no period is ever cut short.

Top module: `pswallow_divider`

## Requirements
- R1: With `mod_sel` = 1 the prescaler base modulus P is 32. With `mod_sel` = 0 it is 64. The `fp` period is N·P + A cycles of `fin_clk`.
- R2: The swallow value A is 7 bits wide and accepted over its full range 0 to 127. A = 0 and A = 127 both give N·P + A.
- R3: The main value N is 11 bits wide and valid from 3 to 2047. The minimum N = 3 gives the exact ratio.
- R4: `fp` is high for exactly one `fin_clk` cycle per period.
- R5: The swallow value must not exceed the main value (A ≤ N). A = N is supported and gives N·(P+1). A > N is unsupported.
- R6: New A, N and `mod_sel` values are sampled only at the end of a period. The period in progress completes with the old values, and the following period uses the new ones.
- R7: The reference output `fr` pulses once every R cycles of `osc_clk`, for R from 3 to 16383, and is high for one cycle.
- R8: A new R value is sampled only when the reference period ends. The period in progress keeps the old length.
- R9: While `rst` is high, `fp` and `fr` are low. The first `fp` pulse comes N·P + A `fin_clk` edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin_clk | input | 1 | Fast input clock to be divided |
| osc_clk | input | 1 | Oscillator clock for the reference divider |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| swallow_val | input | 7 | Swallow count A |
| main_val | input | 11 | Main count N |
| ref_val | input | 14 | Reference ratio R |
| mod_sel | input | 1 | 1: P = 32, 0: P = 64 |
| fp | output | 1 | Divided feedback pulse |
| fr | output | 1 | Divided reference pulse |

## Verification
The bench builds the block with its default parameters: prescaler pair 32/64, widths 7, 11 and 14 bits. These defaults bring both moduli within reach, along with A at 0, 127 and equal to N, and N at its minimum of 3. R is covered at both of its limits, 3 and 16383. The largest main count is left out so that the run stays short. Settings are changed mid-period in both clock domains, so the bench can show that the period in progress keeps its old length.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
    parameter int A_W  = 7;
    parameter int N_W  = 11;
    parameter int R_W  = 14;
    parameter int P_LO = 32;
    parameter int P_HI = 64;
    localparam int PC_W = $clog2(P_HI + 1);
    localparam int N_MIN = 3;
    localparam int R_MIN = 3;

    typedef enum logic {MOD_WIDE = 1'b0, MOD_NARROW = 1'b1} mod_e;

    typedef struct packed {
        logic [A_W-1:0] swallow;
        logic [N_W-1:0] main;
        mod_e           mode;
    } frame_t;

    function automatic logic [PC_W-1:0] last_count(mod_e mode, logic extend);
        int unsigned m;
        m = (mode == MOD_NARROW) ? P_LO : P_HI;
        m = m + (extend ? 1 : 0);
        return PC_W'(m - 1);
    endfunction
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler
    import pswallow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  mod_e mode,
    input  logic extend,
    output logic tc
);
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] top_val;

    always_comb begin
        top_val = last_count(mode, extend);
        tc      = (pc == top_val);
    end

    always_ff @(posedge clk) begin
        if (rst)     pc <= '0;
        else if (tc) pc <= '0;
        else         pc <= pc + PC_W'(1);
    end

    assert_prescale_bound_R1: assert property (@(posedge clk) disable iff (rst)
        pc <= top_val);
endmodule

// File: rtl/psw_frame_ctrl.sv
module psw_frame_ctrl
    import pswallow_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           tc,
    input  logic [A_W-1:0] a_in,
    input  logic [N_W-1:0] n_in,
    input  mod_e           mode_in,
    output logic           extend,
    output mod_e           mode,
    output logic           frame_end
);
    frame_t st;
    frame_t nxt_load;

    always_comb begin
        nxt_load.swallow = a_in;
        nxt_load.main    = n_in;
        nxt_load.mode    = mode_in;
        extend    = (st.swallow != '0);
        mode      = st.mode;
        frame_end = tc && (st.main == N_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            st <= nxt_load;
        end else if (tc) begin
            st.main <= st.main - N_W'(1);
            if (st.swallow != '0) st.swallow <= st.swallow - A_W'(1);
        end
    end

    assert_swallow_le_main_R5: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> ({{(N_W-A_W){1'b0}}, a_in} <= n_in));
    assert_swallow_within_main_R5: assert property (@(posedge clk) disable iff (rst)
        {{(N_W-A_W){1'b0}}, st.swallow} <= st.main);
    assert_main_min_R3: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (n_in >= N_W'(N_MIN)));
    assert_mode_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(frame_end) && !$past(rst)) |-> $stable(st.mode));
endmodule

// File: rtl/psw_ref_div.sv
module psw_ref_div
    import pswallow_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [R_W-1:0] r_in,
    output logic           pulse
);
    logic [R_W-1:0] cnt;
    logic           wrap;

    always_comb wrap = (cnt == R_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= r_in;
            pulse <= 1'b0;
        end else begin
            pulse <= wrap;
            cnt   <= wrap ? r_in : cnt - R_W'(1);
        end
    end

    assert_ref_single_R7: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
    assert_ref_min_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (r_in >= R_W'(R_MIN)));
    assert_ref_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
    import pswallow_pkg::*;
(
    input  logic           fin_clk,
    input  logic           osc_clk,
    input  logic           rst,
    input  logic [A_W-1:0] swallow_val,
    input  logic [N_W-1:0] main_val,
    input  logic [R_W-1:0] ref_val,
    input  logic           mod_sel,
    output logic           fp,
    output logic           fr
);
    logic tc;
    logic extend;
    logic frame_end;
    mod_e mode;
    mod_e mode_in;

    always_comb mode_in = mod_sel ? MOD_NARROW : MOD_WIDE;

    psw_prescaler u_pre (
        .clk(fin_clk), .rst(rst), .mode(mode), .extend(extend), .tc(tc)
    );

    psw_frame_ctrl u_frame (
        .clk(fin_clk), .rst(rst), .tc(tc),
        .a_in(swallow_val), .n_in(main_val), .mode_in(mode_in),
        .extend(extend), .mode(mode), .frame_end(frame_end)
    );

    psw_ref_div u_ref (
        .clk(osc_clk), .rst(rst), .r_in(ref_val), .pulse(fr)
    );

    always_ff @(posedge fin_clk) begin
        if (rst) fp <= 1'b0;
        else     fp <= frame_end;
    end

    assert_fp_single_R4: assert property (@(posedge fin_clk) disable iff (rst)
        fp |=> !fp);
    assert_fp_after_end_R4: assert property (@(posedge fin_clk) disable iff (rst)
        frame_end |=> fp);
endmodule

// File: tb/pswallow_divider_test.sv
module pswallow_divider_test;
    logic        fin_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  swallow_val = 7'd2;
    logic [10:0] main_val = 11'd5;
    logic [13:0] ref_val = 14'd10;
    logic        mod_sel = 1'b1;
    logic        fp, fr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ocyc   = 0;
    bit done   = 0;

    always #4 fin_clk = ~fin_clk;
    initial begin #3; forever #3 osc_clk = ~osc_clk; end

    always @(posedge fin_clk) cyc  <= cyc + 1;
    always @(posedge osc_clk) ocyc <= ocyc + 1;

    pswallow_divider uut (
        .fin_clk(fin_clk), .osc_clk(osc_clk), .rst(rst),
        .swallow_val(swallow_val), .main_val(main_val), .ref_val(ref_val),
        .mod_sel(mod_sel), .fp(fp), .fr(fr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fp(output int stamp);
        do @(negedge fin_clk); while (!fp);
        stamp = cyc;
    endtask

    task automatic wait_fr(output int stamp);
        do @(negedge osc_clk); while (!fr);
        stamp = ocyc;
    endtask

    function automatic int ratio(input bit sw, input int n, input int a);
        return n * (sw ? 32 : 64) + a;
    endfunction

    task automatic t_reset_R9();
        repeat (6) @(negedge fin_clk);
        chk("R9 fp low in reset", int'(fp), 0);
        chk("R9 fr low in reset", int'(fr), 0);
        rst = 1'b0;
        cyc = 0;
        begin
            int s;
            wait_fp(s);
            chk("R9 first fp latency", s, ratio(1'b1, 5, 2));
        end
    endtask

    task automatic t_ratio(input string req, input bit sw, input int n, input int a);
        int s0, s1;
        mod_sel = sw; main_val = 11'(n); swallow_val = 7'(a);
        wait_fp(s0); wait_fp(s0);
        wait_fp(s1);
        chk(req, s1 - s0, ratio(sw, n, a));
        @(negedge fin_clk);
        chk("R4 fp width", int'(fp), 0);
    endtask

    task automatic t_defer_R6();
        int s0, s1, s2;
        mod_sel = 1'b1; main_val = 11'd10; swallow_val = 7'd3;
        wait_fp(s0); wait_fp(s0);
        repeat (5) @(negedge fin_clk);
        mod_sel = 1'b0; main_val = 11'd6; swallow_val = 7'd1;
        wait_fp(s1);
        chk("R6 current period keeps old ratio", s1 - s0, ratio(1'b1, 10, 3));
        wait_fp(s2);
        chk("R6 next period uses new ratio", s2 - s1, ratio(1'b0, 6, 1));
    endtask

    task automatic t_ref(input string req, input int r);
        int s0, s1;
        ref_val = 14'(r);
        wait_fr(s0); wait_fr(s0);
        wait_fr(s1);
        chk(req, s1 - s0, r);
        @(negedge osc_clk);
        chk("R7 fr width", int'(fr), 0);
    endtask

    task automatic t_ref_defer_R8();
        int s0, s1, s2;
        ref_val = 14'd40;
        wait_fr(s0); wait_fr(s0);
        repeat (3) @(negedge osc_clk);
        ref_val = 14'd7;
        wait_fr(s1);
        chk("R8 current ref period keeps old R", s1 - s0, 40);
        wait_fr(s2);
        chk("R8 next ref period uses new R", s2 - s1, 7);
    endtask

    initial begin
        t_reset_R9();
        t_ratio("R1 narrow P=32 N=10 A=3", 1'b1, 10, 3);
        t_ratio("R1 wide P=64 N=4 A=2", 1'b0, 4, 2);
        t_ratio("R3 minimum N=3 A=0", 1'b1, 3, 0);
        t_ratio("R2 A=0 N=20", 1'b1, 20, 0);
        t_ratio("R2 A=127 N=127", 1'b1, 127, 127);
        t_ratio("R5 A equals N wide", 1'b0, 3, 3);
        t_ratio("R1 wide P=64 N=100 A=50", 1'b0, 100, 50);
        t_defer_R6();
        t_ref("R7 minimum R=3", 3);
        t_ref("R7 R=100", 100);
        t_ref_defer_R8();
        t_ref("R7 maximum R=16383", 16383);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge fin_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R4 actual=hung expected=fp/fr pulses");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule